// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer behind a successive-approximation analog-to-digital converter whose analog side is a capacitive comparator and a trial-level DAC. For each conversion it holds the analog multiplexer on one channel and gates a conversion clock derived from the system clock by a selectable ratio. It spends a fixed number of conversion clocks sampling and settling, then runs a bit-by-bit binary search against the comparator. The result goes into a result register selected by the channel's position within its group.

A conversion begins on a rising edge of the software go bit, or in trigger mode on a rising edge of the external trigger while the go bit is high. One-shot operation converts once and stops. Repeat operation reconverts as long as the go bit stays high. Configuration is captured at each start, so edits made while a conversion runs only take effect at the next start. A reference-enable output keeps the resistor ladder powered while a conversion is in flight, and otherwise follows the reference-connect setting.

Top module: `sarc_ctrl`

## Requirements
- R1: In 10-bit mode the search tests `dac_code` bits from bit 9 down to bit 0. Each trial shows the kept bits plus the bit under test. The bit is kept when `cmp_in` is 1 (input at or above the trial level), so an ideal comparator yields the largest code not above the input.
- R2: In 8-bit mode only bits 9 down to 2 are tested. The stored result has bits 1:0 equal to zero.
- R3: `cfg_div` picks the conversion-clock ratio: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 6, and 5, 6 or 7 give 12 system clocks per conversion clock.
- R4: A conversion lasts N conversion clocks: N is 49 (8-bit) or 59 (10-bit) with `cfg_sh`=0, and 28 (8-bit) or 33 (10-bit) with `cfg_sh`=1. `done` is high in the cycle that follows the (N×ratio)-th rising clock edge after the start edge, and `busy` is high from the start edge until then.
- R5: `done` is a single-cycle pulse. It appears in the same cycle as the updated result register.
- R6: The result is written to slot `cfg_ch` of `res_flat` (bits ch×10+9 down to ch×10) whatever the group, and no other slot changes. While busy, `mux_grp` and `mux_ch` show the captured group and channel.
- R7: With `trig_mode`=0 a rising edge of `sw_go` starts a conversion. With `trig_mode`=1, only a rising edge of `ext_trig` while `sw_go` is high starts one.
- R8: A start is ignored while busy, while `cfg_ref_on` is 0, or when `cfg_grp` is 3 (not an existing group).
- R9: Changes to `cfg_div`, `cfg_res10`, `cfg_sh`, `cfg_grp` and `cfg_ch` during a conversion do not affect its length, resolution or destination.
- R10: With `cfg_repeat`=0 the block goes idle after one conversion. With `cfg_repeat`=1 it restarts at once after each completion while `sw_go` is high, and stops after the conversion during which `sw_go` was cleared.
- R11: `ref_en` is 1 while busy. When idle it equals `cfg_ref_on`.
- R12: After reset `busy`, `done`, `dac_code` and every result slot are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_go | input | 1 | Software go bit |
| ext_trig | input | 1 | External trigger |
| trig_mode | input | 1 | 1: start on external trigger edge |
| cfg_ref_on | input | 1 | Reference-connect setting |
| cfg_repeat | input | 1 | 1: repeat mode, 0: one-shot |
| cfg_div | input | 3 | Conversion clock ratio code |
| cfg_res10 | input | 1 | 1: 10-bit, 0: 8-bit |
| cfg_sh | input | 1 | Sample-and-hold enable |
| cfg_grp | input | 2 | Input group select |
| cfg_ch | input | 3 | Channel within group |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial level |
| dac_code | output | 10 | Trial code for the capacitive DAC |
| mux_grp | output | 2 | Group driven to the analog mux |
| mux_ch | output | 3 | Channel driven to the analog mux |
| ref_en | output | 1 | Reference ladder enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| res_flat | output | 80 | Eight 10-bit result slots, slot k at bits k×10+9:k×10 |

## Verification
The bench uses the default build of three groups of eight channels, so the result bank has only eight slots. The whole bank is compared against a bench model after every conversion, which catches a misdirected or stray write at once. With 10-bit codes, all 1024 input levels can be swept through an ideal comparator model at both resolutions using the fastest clock ratio. The search result and the 8-bit truncation are then checked arithmetically. A second sweep covers all eight ratio codes against both resolutions and both sample-and-hold settings, and checks the completion cycle exactly for each combination.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int RES_W  = 10;   // full result width
    localparam int LO_RES = 8;    // reduced resolution
    localparam int DIV_W  = 4;    // holds the largest ratio (12)
    localparam int CNT_W  = 6;    // holds the longest conversion (59)

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic [2:0] div;
        logic       res10;
        logic       sh;
        logic       rep;
    } conv_cfg_t;

    function automatic logic [DIV_W-1:0] div_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd3;
            3'd3:    return 4'd4;
            3'd4:    return 4'd6;
            default: return 4'd12;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] conv_len(input logic res10, input logic sh);
        case ({sh, res10})
            2'b00:   return 6'd49;
            2'b01:   return 6'd59;
            2'b10:   return 6'd28;
            default: return 6'd33;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] trial_count(input logic res10);
        return res10 ? CNT_W'(RES_W) : CNT_W'(LO_RES);
    endfunction

endpackage

// File: rtl/sarc_clkdiv.sv
module sarc_clkdiv
    import sarc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] div_code,
    output logic       tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = div_ratio(div_code) - DIV_W'(1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sarc_seq.sv
module sarc_seq
    import sarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             res10,
    input  logic             sh,
    input  logic             cmp,
    output logic [RES_W-1:0] dac_code,
    output logic             fin,
    output logic [RES_W-1:0] result
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] kept_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] tidx;
    logic             in_trial;
    logic [RES_W-1:0] mask;

    always_comb begin
        len      = conv_len(res10, sh);
        base     = len - trial_count(res10);
        in_trial = (cnt_q >= base);
        tidx     = cnt_q - base;
        mask     = in_trial ? (TOP_BIT >> tidx) : '0;
    end

    assign dac_code = kept_q | mask;
    assign result   = kept_q | (cmp ? mask : '0);
    assign fin      = tick && (cnt_q == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            kept_q <= '0;
        end else if (tick) begin
            kept_q <= result;
            cnt_q  <= fin ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sarc_resbank.sv
module sarc_resbank #(
    parameter int NSLOT = 8,
    parameter int W     = 10,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [W-1:0]       wdata,
    output logic [NSLOT*W-1:0] flat
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                slot_q <= wdata;
            end
        end
        assign flat[g*W +: W] = slot_q;
    end

endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
    import sarc_pkg::*;
#(
    parameter int NUM_GRP    = 3,
    parameter int CH_PER_GRP = 8,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int CH_W  = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sw_go,
    input  logic                        ext_trig,
    input  logic                        trig_mode,
    input  logic                        cfg_ref_on,
    input  logic                        cfg_repeat,
    input  logic [2:0]                  cfg_div,
    input  logic                        cfg_res10,
    input  logic                        cfg_sh,
    input  logic [GRP_W-1:0]            cfg_grp,
    input  logic [CH_W-1:0]             cfg_ch,
    input  logic                        cmp_in,
    output logic [RES_W-1:0]            dac_code,
    output logic [GRP_W-1:0]            mux_grp,
    output logic [CH_W-1:0]             mux_ch,
    output logic                        ref_en,
    output logic                        busy,
    output logic                        done,
    output logic [CH_PER_GRP*RES_W-1:0] res_flat
);

    ctl_state_e       state_q;
    conv_cfg_t        cur_q;
    conv_cfg_t        live_cfg;
    logic [GRP_W-1:0] grp_q;
    logic [CH_W-1:0]  ch_q;
    logic             go_q;
    logic             trig_q;
    logic             done_q;

    logic             grp_ok;
    logic             start_req;
    logic             start_ok;
    logic             restart;
    logic             load;
    logic             tick;
    logic             fin;
    logic [RES_W-1:0] result;
    logic             run_res10;

    assign live_cfg = '{div: cfg_div, res10: cfg_res10, sh: cfg_sh, rep: cfg_repeat};
    assign grp_ok   = int'(cfg_grp) < NUM_GRP;
    assign busy     = (state_q == ST_CONV);

    // start event: software edge, or trigger edge qualified by the go bit
    assign start_req = trig_mode ? (sw_go && ext_trig && !trig_q)
                                 : (sw_go && !go_q);
    assign start_ok  = start_req && !busy && cfg_ref_on && grp_ok;
    assign restart   = fin && cur_q.rep && sw_go && cfg_ref_on && grp_ok;
    assign load      = start_ok || restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            grp_q   <= '0;
            ch_q    <= '0;
            go_q    <= 1'b0;
            trig_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            go_q   <= sw_go;
            trig_q <= ext_trig;
            done_q <= fin;
            if (load) begin
                state_q <= ST_CONV;
                cur_q   <= live_cfg;
                grp_q   <= cfg_grp;
                ch_q    <= cfg_ch;
            end else if (fin) begin
                state_q <= ST_IDLE;
            end
        end
    end

    sarc_clkdiv u_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (load),
        .run      (busy),
        .div_code (cur_q.div),
        .tick     (tick)
    );

    sarc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .clr      (load),
        .tick     (tick),
        .res10    (cur_q.res10),
        .sh       (cur_q.sh),
        .cmp      (cmp_in),
        .dac_code (dac_code),
        .fin      (fin),
        .result   (result)
    );

    sarc_resbank #(
        .NSLOT (CH_PER_GRP),
        .W     (RES_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (fin),
        .idx   (ch_q),
        .wdata (result),
        .flat  (res_flat)
    );

    assign run_res10 = cur_q.res10;
    assign mux_grp   = grp_q;
    assign mux_ch    = ch_q;
    assign done      = done_q;
    assign ref_en    = busy || cfg_ref_on;

endmodule

// File: rtl/sarc_ctrl_chk.sv
module sarc_ctrl_chk
    import sarc_pkg::*;
#(
    parameter int NUM_GRP    = 3,
    parameter int CH_PER_GRP = 8,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int CH_W  = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        busy,
    input logic                        done,
    input logic                        ref_en,
    input logic                        cfg_ref_on,
    input logic [GRP_W-1:0]            mux_grp,
    input logic [CH_W-1:0]             mux_ch,
    input logic                        res10_q,
    input logic [CH_PER_GRP*RES_W-1:0] res_flat
);

    logic [CH_W-1:0] prev_ch;
    logic            prev_r10;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ch  <= '0;
            prev_r10 <= 1'b0;
        end else begin
            prev_ch  <= mux_ch;
            prev_r10 <= res10_q;
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    a_r11_ref_held: assert property (@(posedge clk) disable iff (rst)
        busy |-> ref_en);

    a_r8_no_start_ref_off: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_ref_on) |=> !busy);

    a_r9_mux_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || done || ($stable(mux_grp) && $stable(mux_ch))));

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !prev_r10) |-> (res_flat[prev_ch*RES_W +: 2] == 2'b00));

endmodule

bind sarc_ctrl sarc_ctrl_chk #(
    .NUM_GRP    (NUM_GRP),
    .CH_PER_GRP (CH_PER_GRP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .ref_en     (ref_en),
    .cfg_ref_on (cfg_ref_on),
    .mux_grp    (mux_grp),
    .mux_ch     (mux_ch),
    .res10_q    (run_res10),
    .res_flat   (res_flat)
);

// File: tb/sarc_ctrl_tb.sv
`timescale 1ns/1ps
module sarc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       sw_go, ext_trig, trig_mode, cfg_ref_on, cfg_repeat;
    logic [2:0] cfg_div;
    logic       cfg_res10, cfg_sh;
    logic [1:0] cfg_grp;
    logic [2:0] cfg_ch;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [1:0] mux_grp;
    logic [2:0] mux_ch;
    logic       ref_en, busy, done;
    logic [79:0] res_flat;

    logic [9:0] vin;
    logic [9:0] exp_bank [8];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // ideal comparator
    assign cmp_in = (vin >= dac_code);

    sarc_ctrl u_dut (
        .clk(clk), .rst(rst), .sw_go(sw_go), .ext_trig(ext_trig),
        .trig_mode(trig_mode), .cfg_ref_on(cfg_ref_on), .cfg_repeat(cfg_repeat),
        .cfg_div(cfg_div), .cfg_res10(cfg_res10), .cfg_sh(cfg_sh),
        .cfg_grp(cfg_grp), .cfg_ch(cfg_ch), .cmp_in(cmp_in),
        .dac_code(dac_code), .mux_grp(mux_grp), .mux_ch(mux_ch),
        .ref_en(ref_en), .busy(busy), .done(done), .res_flat(res_flat)
    );

    function automatic int ratio(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            default: return 12;
        endcase
    endfunction

    function automatic int clen(input bit r10, input bit sh);
        if (sh) return r10 ? 33 : 28;
        return r10 ? 59 : 49;
    endfunction

    function automatic logic [9:0] exp_code(input int v, input bit r10);
        logic [9:0] c;
        c = v[9:0];
        return r10 ? c : (c & 10'h3FC);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < 8; i++)
            chk(res_flat[i*10 +: 10] == exp_bank[i], req,
                int'(res_flat[i*10 +: 10]), int'(exp_bank[i]));
    endtask

    task automatic run_conv(input int dv, input bit r10, input bit sh,
                            input int grp, input int ch, input int v,
                            input bit disturb);
        int len;
        string rtag;
        len  = clen(r10, sh) * ratio(dv);
        rtag = r10 ? "R1 result" : "R2 result";
        @(negedge clk);
        cfg_div = dv[2:0]; cfg_res10 = r10; cfg_sh = sh;
        cfg_grp = grp[1:0]; cfg_ch = ch[2:0]; vin = v[9:0];
        sw_go = 1'b0; trig_mode = 1'b0; cfg_repeat = 1'b0;
        @(negedge clk);
        sw_go = 1'b1;
        @(posedge clk);                       // start edge
        for (int e = 1; e < len; e++) begin
            @(posedge clk);
            if (disturb && e == 3) begin      // R9: edit config mid-run
                @(negedge clk);
                cfg_res10 = ~r10; cfg_sh = ~sh; cfg_div = 3'(dv + 3);
                cfg_grp = 2'((grp + 1) % 3); cfg_ch = 3'(ch + 1);
                cfg_ref_on = 1'b0; sw_go = 1'b0;
            end
            if (disturb && e == 4) begin
                @(negedge clk);
                chk(ref_en == 1'b1, "R11 ref held while busy", int'(ref_en), 1);
                sw_go = 1'b1;                 // R8: edge while busy ignored
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R4 done not early", int'(done), 0);
        chk(busy == 1'b1, "R4 busy during run", int'(busy), 1);
        chk(mux_grp == grp[1:0], "R6 mux group", int'(mux_grp), grp);
        chk(mux_ch == ch[2:0], "R6 mux channel", int'(mux_ch), ch);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R4 done at N*ratio", int'(done), 1);
        exp_bank[ch] = exp_code(v, r10);
        chk(res_flat[ch*10 +: 10] == exp_bank[ch], rtag,
            int'(res_flat[ch*10 +: 10]), int'(exp_bank[ch]));
        chk_bank("R6 bank slot");
        chk(busy == 1'b0, "R10 one-shot idle", int'(busy), 0);
        if (disturb) chk(ref_en == 1'b0, "R11 ref follows cfg when idle", int'(ref_en), 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
        chk(busy == 1'b0, "R10 no restart in one-shot", int'(busy), 0);
        sw_go = 1'b0; cfg_ref_on = 1'b1;
    endtask

    initial begin
        #(4 * 195000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_go = 1'b0; ext_trig = 1'b0; trig_mode = 1'b0;
        cfg_ref_on = 1'b0; cfg_repeat = 1'b0; cfg_div = 3'd0;
        cfg_res10 = 1'b1; cfg_sh = 1'b1; cfg_grp = 2'd0; cfg_ch = 3'd0; vin = '0;
        for (int i = 0; i < 8; i++) exp_bank[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(busy == 1'b0, "R12 busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R12 done after reset", int'(done), 0);
        chk(dac_code == 10'd0, "R12 dac after reset", int'(dac_code), 0);
        chk_bank("R12 slots after reset");
        chk(ref_en == 1'b0, "R11 ref idle off", int'(ref_en), 0);
        cfg_ref_on = 1'b1;
        @(negedge clk);
        chk(ref_en == 1'b1, "R11 ref idle on", int'(ref_en), 1);

        // R3/R4: every ratio code against both resolutions and S/H settings
        for (int d = 0; d < 8; d++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++)
                    run_conv(d, r[0], s[0], (d + s) % 3, (d + r) % 8,
                             (d * 97 + r * 301 + s * 55 + 13) % 1024, 1'b0);

        // R1/R2: all input levels at both resolutions
        for (int r = 0; r < 2; r++)
            for (int v = 0; v < 1024; v++)
                run_conv(0, r[0], 1'b1, v % 3, v % 8, v, 1'b0);

        // R9/R8/R11: configuration edits and a go edge during a conversion
        run_conv(1, 1'b1, 1'b0, 0, 3, 10'h2E9, 1'b1);
        run_conv(2, 1'b0, 1'b1, 2, 6, 10'h0D7, 1'b1);

        // R6: same channel index in two groups shares one slot
        run_conv(0, 1'b1, 1'b1, 2, 5, 10'h155, 1'b0);
        run_conv(0, 1'b1, 1'b1, 1, 5, 10'h2AA, 1'b0);

        // R8: start refused with reference off, and with group code 3
        @(negedge clk);
        cfg_ref_on = 1'b0; cfg_grp = 2'd0;
        @(negedge clk); sw_go = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 start ignored ref off", int'(busy), 0);
        chk(ref_en == 1'b0, "R11 ref off idle", int'(ref_en), 0);
        sw_go = 1'b0; cfg_ref_on = 1'b1; cfg_grp = 2'd3;
        @(negedge clk); sw_go = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 start ignored group 3", int'(busy), 0);
        repeat (60) @(negedge clk);
        chk(done == 1'b0, "R8 no completion", int'(done), 0);
        chk_bank("R8 bank untouched");
        sw_go = 1'b0; cfg_grp = 2'd1;

        // R7: trigger mode, ratio 3, 8-bit with S/H -> 84 cycles
        @(negedge clk);
        trig_mode = 1'b1; cfg_div = 3'd2; cfg_res10 = 1'b0; cfg_sh = 1'b1;
        cfg_ch = 3'd7; vin = 10'h3B6;
        ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7 trigger without go ignored", int'(busy), 0);
        sw_go = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R7 go edge ignored in trigger mode", int'(busy), 0);
        ext_trig = 1'b1;
        @(posedge clk);
        @(negedge clk); ext_trig = 1'b0;
        chk(busy == 1'b1, "R7 trigger starts", int'(busy), 1);
        repeat (84 - 1) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R7 done not early", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R7 done after trigger", int'(done), 1);
        exp_bank[7] = exp_code(10'h3B6, 1'b0);
        chk_bank("R7 result slot");
        sw_go = 1'b0; trig_mode = 1'b0;

        // R10: repeat mode, 10-bit with S/H, ratio 1 -> 33 cycles
        @(negedge clk);
        cfg_repeat = 1'b1; cfg_div = 3'd0; cfg_res10 = 1'b1; cfg_sh = 1'b1;
        cfg_grp = 2'd0; cfg_ch = 3'd2; vin = 10'h111;
        @(negedge clk); sw_go = 1'b1;
        @(posedge clk);
        repeat (32) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10 first not early", int'(done), 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b1, "R10 first done", int'(done), 1);
        exp_bank[2] = 10'h111;
        chk_bank("R10 first result");
        vin = 10'h3C4;
        repeat (32) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R10 restarted", int'(busy), 1);
        chk(done == 1'b0, "R10 second not early", int'(done), 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b1, "R10 second done", int'(done), 1);
        exp_bank[2] = 10'h3C4;
        chk_bank("R10 second result");
        sw_go = 1'b0; vin = 10'h07B;
        repeat (32) @(posedge clk);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b1, "R10 final done", int'(done), 1);
        exp_bank[2] = 10'h07B;
        chk_bank("R10 final result");
        chk(busy == 1'b0, "R10 stops after go cleared", int'(busy), 0);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R10 stays idle", int'(busy), 0);
        chk(done == 1'b0, "R10 no further done", int'(done), 0);
        cfg_repeat = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule